// File: doc/BRIEF.md
# Dual Smart Card Channel Router

This block connects one host-side card interface (a reset level, a card clock and an open-drain data line) to one of two card channels. A select input picks the channel that talks to the host. Each channel also has an enable, a ready flag from the supply sequencer, and a run-clock option.

A card that is not selected keeps its reset level frozen. If its run-clock option is set, it also keeps its clock. This lets the host move between two initialised cards without starting either one again.

Open-drain lines are modelled as "pull low" drive flags plus pull-up flags. A channel counts as live only when it is both enabled and ready. Nothing on a card pin is driven or pulled before that point.

The host clock is an input sampled in the system clock domain. The enable of each card clock gate is registered, and it is allowed to move only while the host clock is low. This way no card sees a clipped pulse.

Top module: `scard_router`

## Requirements
- R1: A select value of 0 connects channel A (index 0) and a value of 1 connects channel B (index 1). At most one channel is connected to the host data line at any time.
- R2: The card reset output of the selected, live channel equals the host reset input in the same cycle.
- R3: A live channel that is not selected keeps the card reset level it had when it was last selected, until it is selected again.
- R4: A deselected channel's card I/O is not driven low, and its pull-up flag is 1. A low driven by that card does not reach the host data line.
- R5: A live channel's card clock copies the host clock whenever that channel is selected or its run-clock input is 1.
- R6: A live channel that is deselected with its run-clock input at 0 has its card clock held low no later than two host clock periods after the change.
- R7: When no channel is connected, the host pull-up flag is 1 and the block does not pull the host data line low.
- R8: A channel that is not both enabled and ready drives its card clock, card reset and card I/O pull-low to 0, and its pull-up flag to 0.
- R9: Every card clock high pulse lasts exactly one full host clock high phase. The gate enable changes only in cycles where the host clock was low.
- R10: On the connected channel, a host pull-low drives the card I/O pull-low, and a card pull-low drives the host pull-low.
- R11: After the select input changes, the newly selected channel's reset output follows the host reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | SEL_W | Selected channel index |
| chan_en | input | N_CH | Per-channel enable |
| chan_rdy | input | N_CH | Per-channel supply ready flag from the sequencer |
| clk_run | input | N_CH | Keep clock running when the channel is deselected |
| host_clk | input | 1 | Host card clock, synchronous to clk |
| host_rst | input | 1 | Host card reset level |
| host_dat_low | input | 1 | Host is pulling the data line low |
| card_dat_low | input | N_CH | Card is pulling its I/O line low |
| card_clk | output | N_CH | Gated card clock per channel |
| card_rst | output | N_CH | Card reset level per channel |
| card_io_low | output | N_CH | Block pulls card I/O low |
| card_io_pu | output | N_CH | Card I/O pull-up active |
| host_dat_pull | output | 1 | Block pulls host data line low |
| host_dat_pu | output | 1 | Weak host data pull-up active |

## Verification
The bench builds the router with its defaults: two channels and a one-bit select. This covers every select value and lets each channel play both the selected and the deselected role within one run.

The host clock is driven with a four-cycle high phase. That makes clipped pulses and late gate release visible as pulse lengths other than four. It also makes "within two host periods" a sixteen-cycle window.

The scenarios toggle the run option at varying offsets against the host clock phase. They also exercise reset hold across repeated select changes and the not-ready gating.

// File: rtl/scard_pkg.sv
// Package: shared helpers for the card router.
// Assumes: nothing beyond standard SystemVerilog.
package scard_pkg;

    // Select width for a given channel count, never below one bit.
    function automatic int sel_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/scard_clk_gate.sv
// Module: per-channel card clock gate.
// What it does: it passes host_clk to the card while `want` is set.
// The gate register updates only in cycles where host_clk is low, so a
// pulse is either passed whole or suppressed whole.
// Assumes: host_clk is generated synchronously to clk and each of its
// phases spans at least one clk cycle.
module scard_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clk,
    input  logic live,
    input  logic want,
    output logic card_clk
);

    logic gate_q;

    // Purpose: move the gate only while the host clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (!host_clk)
            gate_q <= want;
    end

    // Purpose: an unpowered channel never sees a clock edge.
    always_comb card_clk = host_clk & gate_q & live;

    // R9: the gate changes only after a low host clock sample.
    a_r9_gate_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q != $past(gate_q)) |-> !$past(host_clk));

    // R6: after a low host-clock cycle with no request, the gate is shut.
    a_r6_gate_shut: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!want) && !$past(host_clk)) |-> !gate_q);

endmodule

// File: rtl/scard_rst_hold.sv
// Module: per-channel card reset path.
// What it does: the selected channel follows host_rst combinationally.
// A deselected channel replays the level captured on its last selected
// cycle. A channel that is not live is held low and loses its stored level.
// Assumes: selection and liveness are decided by the parent.
module scard_rst_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic selected,
    input  logic host_rst,
    output logic card_rst
);

    logic held_q;

    // Purpose: capture the level while selected, clear it when not live.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (!live)
            held_q <= 1'b0;
        else if (selected)
            held_q <= host_rst;
    end

    // Purpose: choose the live source or the frozen level.
    always_comb card_rst = live & (selected ? host_rst : held_q);

    // R3: a live, deselected channel keeps a steady reset level.
    a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !selected && $past(live) && !$past(selected)) |-> $stable(card_rst));

    // R8: the stored level is dropped once the channel is not live.
    a_r8_held_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!live) |-> !held_q);

endmodule

// File: rtl/scard_io_switch.sv
// Module: open-drain data switch between the host line and N card lines.
// What it does: the connected channel passes a pull-low in both directions.
// Every live channel keeps its card pull-up on. The host pull-up is on
// when no channel is connected.
// Assumes: at most one bit of `conn` is set.
module scard_io_switch #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] conn,
    input  logic [N_CH-1:0] live,
    input  logic            host_dat_low,
    input  logic [N_CH-1:0] card_dat_low,
    output logic [N_CH-1:0] card_io_low,
    output logic [N_CH-1:0] card_io_pu,
    output logic            host_dat_pull,
    output logic            host_dat_pu
);

    // Purpose: steer host pull-low to the connected card only.
    always_comb begin
        for (int c = 0; c < N_CH; c++)
            card_io_low[c] = conn[c] & host_dat_low;
    end

    // Purpose: pull-ups, card-to-host low, and host keeper.
    always_comb begin
        card_io_pu    = live;
        host_dat_pull = |(conn & card_dat_low);
        host_dat_pu   = ~|conn;
    end

    // R1: never more than one channel connected.
    a_r1_single_conn: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conn));

    // R7: the host keeper and the block's own pull-low never coincide.
    a_r7_keeper_excl: assert property (@(posedge clk) disable iff (!rst_n)
        host_dat_pu |-> !host_dat_pull);

endmodule

// File: rtl/scard_router.sv
// Module: top of the dual card channel router.
// What it does: it routes host reset, clock and data to the channel picked
// by chan_sel. Each channel is live only while enabled and ready.
// Assumes: chan_sel values at or above N_CH select nothing, and host_clk
// is synchronous to clk.
module scard_router
    import scard_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int SEL_W = sel_width(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic [N_CH-1:0]  chan_en,
    input  logic [N_CH-1:0]  chan_rdy,
    input  logic [N_CH-1:0]  clk_run,
    input  logic             host_clk,
    input  logic             host_rst,
    input  logic             host_dat_low,
    input  logic [N_CH-1:0]  card_dat_low,
    output logic [N_CH-1:0]  card_clk,
    output logic [N_CH-1:0]  card_rst,
    output logic [N_CH-1:0]  card_io_low,
    output logic [N_CH-1:0]  card_io_pu,
    output logic             host_dat_pull,
    output logic             host_dat_pu
);

    logic [N_CH-1:0] live;
    logic [N_CH-1:0] picked;
    logic [N_CH-1:0] conn;

    // Purpose: liveness per channel from enable and supply ready.
    always_comb live = chan_en & chan_rdy;

    // Purpose: connection = live and picked by the select.
    always_comb conn = live & picked;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        localparam logic [SEL_W-1:0] IDX = SEL_W'(g);

        // Purpose: decode the select for this channel.
        always_comb picked[g] = (chan_sel == IDX);

        scard_clk_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .host_clk (host_clk),
            .live     (live[g]),
            .want     (live[g] & (picked[g] | clk_run[g])),
            .card_clk (card_clk[g])
        );

        scard_rst_hold u_rst (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (live[g]),
            .selected (picked[g]),
            .host_rst (host_rst),
            .card_rst (card_rst[g])
        );
    end

    scard_io_switch #(.N_CH(N_CH)) u_io (
        .clk           (clk),
        .rst_n         (rst_n),
        .conn          (conn),
        .live          (live),
        .host_dat_low  (host_dat_low),
        .card_dat_low  (card_dat_low),
        .card_io_low   (card_io_low),
        .card_io_pu    (card_io_pu),
        .host_dat_pull (host_dat_pull),
        .host_dat_pu   (host_dat_pu)
    );

endmodule

// File: tb/scard_router_tb_top.sv
`timescale 1ns/1ps
module scard_router_tb_top;

    localparam int N    = 2;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [0:0]   chan_sel = 1'b0;
    logic [N-1:0] chan_en = '0, chan_rdy = '0, clk_run = '0, card_dat_low = '0;
    logic         host_clk = 1'b0, host_rst = 1'b0, host_dat_low = 1'b0;
    logic [N-1:0] card_clk, card_rst, card_io_low, card_io_pu;
    logic         host_dat_pull, host_dat_pu;

    int n_chk = 0;
    int n_bad = 0;
    int hcnt = 0;
    bit mon_on = 1'b0;
    int plen [N];

    always #2 clk = ~clk;

    scard_router dut_i (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .chan_en(chan_en),
        .chan_rdy(chan_rdy), .clk_run(clk_run), .host_clk(host_clk),
        .host_rst(host_rst), .host_dat_low(host_dat_low),
        .card_dat_low(card_dat_low), .card_clk(card_clk), .card_rst(card_rst),
        .card_io_low(card_io_low), .card_io_pu(card_io_pu),
        .host_dat_pull(host_dat_pull), .host_dat_pu(host_dat_pu)
    );

    // Host clock: HALF system cycles per phase, driven at the falling edge.
    always @(negedge clk) begin
        hcnt <= (hcnt == HALF - 1) ? 0 : hcnt + 1;
        if (hcnt == HALF - 1) host_clk <= ~host_clk;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    // R9 monitor: every card clock pulse spans a whole host high phase.
    always @(negedge clk) begin
        #1;
        for (int c = 0; c < N; c++) begin
            if (!mon_on) plen[c] = 0;
            else if (card_clk[c]) plen[c]++;
            else if (plen[c] > 0) begin
                check("R9 pulse length", plen[c], HALF);
                plen[c] = 0;
            end
        end
    end

    task automatic t_reset_state();
        check("R8 reset clk", card_clk, 0);
        check("R8 reset rst", card_rst, 0);
        check("R8 reset io", card_io_low, 0);
        check("R7 reset keeper", host_dat_pu, 1);
    endtask

    task automatic t_not_ready();
        chan_en = 2'b11; chan_rdy = 2'b00; host_rst = 1; host_dat_low = 1;
        card_dat_low = 2'b11; chan_sel = 0;
        for (int i = 0; i < 2 * 2 * HALF; i++) begin
            step(1);
            check("R8 clk gated", card_clk, 0);
        end
        check("R8 rst gated", card_rst, 0);
        check("R8 io gated", card_io_low, 0);
        check("R8 pull-up off", card_io_pu, 0);
        check("R7 keeper on", host_dat_pu, 1);
        check("R7 no host low", host_dat_pull, 0);
        host_rst = 0; host_dat_low = 0; card_dat_low = 0;
    endtask

    task automatic t_route();
        chan_rdy = 2'b11; chan_en = 2'b11; chan_sel = 0; step(1);
        host_dat_low = 1; #1;
        check("R1 R10 host low to A", card_io_low, 2'b01);
        host_dat_low = 0; card_dat_low = 2'b10; #1;
        check("R4 B low blocked", host_dat_pull, 0);
        card_dat_low = 2'b01; #1;
        check("R10 A low to host", host_dat_pull, 1);
        check("R4 pull-ups", card_io_pu, 2'b11);
        check("R7 keeper off", host_dat_pu, 0);
        chan_sel = 1; card_dat_low = 0; host_dat_low = 1; #1;
        check("R1 R10 host low to B", card_io_low, 2'b10);
        host_dat_low = 0; card_dat_low = 2'b01; #1;
        check("R4 A low blocked", host_dat_pull, 0);
        card_dat_low = 2'b10; #1;
        check("R10 B low to host", host_dat_pull, 1);
        card_dat_low = 0; step(1);
    endtask

    task automatic t_reset_hold();
        chan_sel = 0; host_rst = 1; step(2);
        check("R2 A follows 1", card_rst[0], 1);
        chan_sel = 1; host_rst = 0; #1;
        check("R11 B follows at once", card_rst[1], 0);
        check("R3 A held 1", card_rst[0], 1);
        for (int i = 0; i < 4; i++) begin
            host_rst = ~host_rst; step(1);
            check("R2 B follows", card_rst[1], host_rst);
            check("R3 A frozen", card_rst[0], 1);
        end
        host_rst = 0; step(1);
        chan_sel = 0; #1;
        check("R11 A follows at once", card_rst[0], 0);
        check("R3 B held 0", card_rst[1], 0);
        host_rst = 1; step(1);
        check("R2 A follows", card_rst[0], 1);
        check("R3 B frozen", card_rst[1], 0);
        host_rst = 0; step(1);
    endtask

    task automatic t_clock();
        mon_on = 1; chan_sel = 0; clk_run = 2'b00; step(4 * HALF);
        for (int i = 0; i < 4 * HALF; i++) begin
            step(1);
            check("R5 A copies host", card_clk[0], host_clk);
            check("R6 B idle", card_clk[1], 0);
        end
        clk_run = 2'b10; step(4 * HALF);
        for (int i = 0; i < 4 * HALF; i++) begin
            step(1);
            check("R5 B runs deselected", card_clk[1], host_clk);
        end
        chan_sel = 1; clk_run = 2'b00; step(4 * HALF);
        for (int i = 0; i < 4 * HALF; i++) begin
            step(1);
            check("R6 A stopped", card_clk[0], 0);
            check("R5 B copies host", card_clk[1], host_clk);
        end
    endtask

    task automatic t_glitch();
        chan_sel = 0;
        for (int i = 0; i < 12; i++) begin
            clk_run[1] = ~clk_run[1];
            clk_run[0] = i[1];
            chan_sel = i[2];
            step(i + 3);
        end
        clk_run = 0; chan_sel = 0; step(4 * HALF);
        mon_on = 0;
    endtask

    task automatic t_none();
        chan_en = 2'b00; step(2);
        card_dat_low = 2'b11; #1;
        check("R7 keeper when none", host_dat_pu, 1);
        check("R7 no pass when none", host_dat_pull, 0);
        check("R8 disabled rst", card_rst, 0);
        card_dat_low = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        t_reset_state();
        rst_n = 1; step(1);
        t_reset_state();
        t_not_ready();
        t_route();
        t_reset_hold();
        t_clock();
        t_glitch();
        t_none();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule